// File: doc/BRIEF.md
# Seconds Real-Time Clock with Register Slave

This peripheral keeps time as a free-running 32-bit count of seconds. A prescaler divides the system clock down to one tick per second, and each tick advances the count. Software sits on an APB-style slave port inside a 4 KB window. Through that port it can preset the count, program an alarm value, and enable, observe and acknowledge a single interrupt. The interrupt leaves the block as a level signal.

The slave never inserts wait states and never signals an error. The clock cannot be stopped. Its control word is fixed at "running" and ignores writes. The top eight words of the window hold a read-only identification table, one byte per word, which a driver can probe to recognise the part.

Top module: `rtc_seconds`

## Requirements
- R1: After reset the seconds count, match value, load value, mask bit and raw status are all zero and `irq_o` is low. `pready` is always 1 and `pslverr` is always 0.
- R2: A tick occurs once every CLK_HZ clock cycles, counted from reset. Each tick adds one to the seconds count. A read of word offset 0x00 returns the present count.
- R3: A write to offset 0x08 replaces the seconds count from the next cycle onward. A read of 0x08 returns the last value written there, not the count. When the write and a tick share a cycle, the written value wins.
- R4: Offset 0x04 holds the match value. A read returns the last value written.
- R5: The mask register at offset 0x10 keeps only bit 0 of a write. Its bits 31:1 read as zero.
- R6: Any write to offset 0x1C clears the raw status. If a match event (R8) falls in the same cycle, the status stays set.
- R7: Offset 0x18 reads raw status AND mask in bit 0. `irq_o` carries that same value.
- R8: Raw status (offset 0x14, bit 0) becomes 1 when the count takes a new value, by tick or by load, that equals the match value held before that cycle.
- R9: Offset 0x0C always reads 1. Writes to it change neither that value nor the counting.
- R10: Offsets 0xFE0 to 0xFFC read, in bits 7:0, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, chosen by (offset − 0xFE0) >> 2. Bits 31:8 read zero. Writes there are ignored.
- R11: Offsets 0x1C, 0x20 to 0xFDC and any address with bits 1:0 nonzero read zero. Writes to reserved offsets change no readable state.
- R12: The count wraps from 0xFFFFFFFF to 0 on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| irq_o | output | 1 | Level interrupt, raw status AND mask |

## Verification
Two pairs of events can collide in one cycle. The first is a software load against a prescaler tick, where the load must win. The second is a clear write against a match event, where the status must stay set. The bench tracks the prescaler phase in its own model. It starts each such access so that its access edge lands exactly on the tick edge. It then reads the count or the raw status back over the bus and compares the result with the outcome the priority rules predict. Random traffic with a short prescaler also produces these collisions by chance, and every read is compared against the model.

// File: rtl/rtc_seconds_pkg.sv
package rtc_seconds_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned WIDX_W = ADDR_W - 2;

    localparam logic [WIDX_W-1:0] W_SECS   = 10'h000;
    localparam logic [WIDX_W-1:0] W_MATCH  = 10'h001;
    localparam logic [WIDX_W-1:0] W_LOAD   = 10'h002;
    localparam logic [WIDX_W-1:0] W_CTRL   = 10'h003;
    localparam logic [WIDX_W-1:0] W_MASK   = 10'h004;
    localparam logic [WIDX_W-1:0] W_RAW    = 10'h005;
    localparam logic [WIDX_W-1:0] W_MIS    = 10'h006;
    localparam logic [WIDX_W-1:0] W_CLR    = 10'h007;
    localparam logic [WIDX_W-1:0] W_ID_LO  = 10'h3F8;

    typedef struct packed {
        logic [DATA_W-1:0] match;
        logic [DATA_W-1:0] load;
        logic              mask;
        logic              raw;
    } rtc_regs_t;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_HZ - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    generate
        if (CLK_HZ > 1) begin : g_div
            always_comb begin
                tick_o = (cnt_q == LAST);
                cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
            end
        end else begin : g_pass
            always_comb begin
                tick_o = 1'b1;
                cnt_d  = '0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (CLK_HZ > 1) begin : g_chk
            // R2: ticks are isolated single-cycle pulses
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] next_o,
    output logic         upd_o
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load_i)      count_d = load_val_i;
        else if (tick_i) count_d = count_q + 1'b1;
        upd_o  = load_i | tick_i;
        next_o = count_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    // R3: a load lands exactly, even with a tick in the same cycle
    p_load_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_o == $past(load_val_i));
    // R2 / R12: a plain tick adds one, wrapping at the top
    p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> count_o == $past(count_o) + 1'b1);
    // R9: without tick or load the count holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/rtc_id_rom.sv
module rtc_id_rom (
    input  logic [2:0] idx_i,
    output logic [7:0] byte_o
);
    always_comb begin
        case (idx_i)
            3'd0:    byte_o = 8'h31;
            3'd1:    byte_o = 8'h10;
            3'd2:    byte_o = 8'h14;
            3'd3:    byte_o = 8'h00;
            3'd4:    byte_o = 8'h0D;
            3'd5:    byte_o = 8'hF0;
            3'd6:    byte_o = 8'h05;
            default: byte_o = 8'hB1;
        endcase
    end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
    import rtc_seconds_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq_o
);
    rtc_regs_t st_d, st_q;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              wr_en;
    logic              tick;
    logic              load_en;
    logic              cnt_upd;
    logic              hit_set;
    logic              clr_en;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_next;
    logic [7:0]        id_byte;

    assign widx    = paddr[ADDR_W-1:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign wr_en   = psel & penable & pwrite & aligned;
    assign load_en = wr_en & (widx == W_LOAD);
    assign clr_en  = wr_en & (widx == W_CLR);

    rtc_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rtc_sec_counter #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load_en),
        .load_val_i (pwdata),
        .count_o    (cnt_q),
        .next_o     (cnt_next),
        .upd_o      (cnt_upd)
    );

    rtc_id_rom u_id (
        .idx_i  (paddr[4:2]),
        .byte_o (id_byte)
    );

    always_comb begin
        st_d    = st_q;
        hit_set = cnt_upd && (cnt_next == st_q.match);
        if (wr_en) begin
            case (widx)
                W_MATCH: st_d.match = pwdata;
                W_LOAD:  st_d.load  = pwdata;
                W_MASK:  st_d.mask  = pwdata[0];
                default: ;
            endcase
        end
        if (hit_set)     st_d.raw = 1'b1;
        else if (clr_en) st_d.raw = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        prdata = '0;
        if (aligned) begin
            if (widx >= W_ID_LO) begin
                prdata = {{(DATA_W-8){1'b0}}, id_byte};
            end else begin
                case (widx)
                    W_SECS:  prdata = cnt_q;
                    W_MATCH: prdata = st_q.match;
                    W_LOAD:  prdata = st_q.load;
                    W_CTRL:  prdata = {{(DATA_W-1){1'b0}}, 1'b1};
                    W_MASK:  prdata = {{(DATA_W-1){1'b0}}, st_q.mask};
                    W_RAW:   prdata = {{(DATA_W-1){1'b0}}, st_q.raw};
                    W_MIS:   prdata = {{(DATA_W-1){1'b0}}, st_q.raw & st_q.mask};
                    default: prdata = '0;
                endcase
            end
        end
    end

    assign irq_o   = st_q.raw & st_q.mask;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // R8: a counter update that lands on the match value raises the status
    p_match_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_upd && cnt_next == st_q.match) |=> st_q.raw);
    // R6: a clear without a coinciding match drops the status
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(cnt_upd && cnt_next == st_q.match)) |=> !st_q.raw);
    // R5: the mask captures bit 0 of its write
    p_mask_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_MASK) |=> st_q.mask == $past(pwdata[0]));
    // R4: the match value changes only through its own write
    p_match_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && widx == W_MATCH) |=> $stable(st_q.match));
endmodule

// File: tb/rtc_seconds_tb.sv
module rtc_seconds_tb;
    localparam int unsigned HZ = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rtc_seconds #(.CLK_HZ(HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_o(irq_o)
    );

    // reference model built from the requirements
    int unsigned m_pc = 0;
    logic [31:0] m_cnt = 0, m_match = 0, m_load = 0;
    logic        m_mask = 0, m_raw = 0;
    logic        t_tick, t_wr, t_upd;
    logic [31:0] t_new;
    logic [9:0]  t_w;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc <= 0; m_cnt <= 0; m_match <= 0; m_load <= 0; m_mask <= 0; m_raw <= 0;
        end else begin
            t_tick = (m_pc == HZ - 1);
            t_wr   = psel && penable && pwrite && (paddr[1:0] == 2'b00);
            t_w    = paddr[11:2];
            t_new  = m_cnt;
            t_upd  = 1'b0;
            if (t_wr && t_w == 10'd2) begin t_new = pwdata; t_upd = 1'b1; m_load <= pwdata; end
            else if (t_tick)          begin t_new = m_cnt + 1; t_upd = 1'b1; end
            m_pc  <= t_tick ? 0 : m_pc + 1;
            m_cnt <= t_new;
            if (t_wr && t_w == 10'd1) m_match <= pwdata;
            if (t_wr && t_w == 10'd4) m_mask  <= pwdata[0];
            if (t_upd && t_new == m_match)  m_raw <= 1'b1;
            else if (t_wr && t_w == 10'd7)  m_raw <= 1'b0;
        end
    end

    function automatic logic [7:0] id_of(input logic [2:0] i);
        case (i)
            3'd0: return 8'h31; 3'd1: return 8'h10; 3'd2: return 8'h14; 3'd3: return 8'h00;
            3'd4: return 8'h0D; 3'd5: return 8'hF0; 3'd6: return 8'h05; default: return 8'hB1;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [9:0] w = a[11:2];
        if (a[1:0] != 2'b00) return 32'd0;
        if (w >= 10'h3F8) return {24'd0, id_of(w[2:0])};
        case (w)
            10'd0: return m_cnt;
            10'd1: return m_match;
            10'd2: return m_load;
            10'd3: return 32'd1;
            10'd4: return {31'd0, m_mask};
            10'd5: return {31'd0, m_raw};
            10'd6: return {31'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [11:0] a);
        logic [9:0] w = a[11:2];
        if (a[1:0] != 2'b00) return "R11";
        if (w >= 10'h3F8) return "R10";
        case (w)
            10'd0: return "R2"; 10'd1: return "R4"; 10'd2: return "R3"; 10'd3: return "R9";
            10'd4: return "R5"; 10'd5: return "R8"; 10'd6: return "R7"; default: return "R11";
        endcase
    endfunction

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] v);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        v = prdata;
        chk(req_of(a), prdata, exp_rd(a));
        chk("R7", {31'd0, irq_o}, {31'd0, m_raw & m_mask});
        chk("R1", {30'd0, pready, pslverr}, 32'd2);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    // start a write so that its access edge coincides with a tick edge
    task automatic apb_wr_on_tick(input logic [11:0] a, input logic [31:0] d);
        while (m_pc != HZ - 2) @(negedge clk);
        apb_wr(a, d);
    endtask

    logic [31:0] rv;
    logic [11:0] pool [12] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
                               12'h018, 12'h01C, 12'h020, 12'h7F4, 12'hFE8, 12'hFFC};

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values through the bus
        for (int i = 0; i < 12; i++) apb_rd(pool[i], rv);
        chk("R1", {31'd0, irq_o}, 32'd0);

        // R2: counting over several periods
        repeat (3 * HZ) @(negedge clk);
        apb_rd(12'h000, rv);

        // R10: every identification word, and a write there is ignored
        for (int i = 0; i < 8; i++) apb_rd(12'hFE0 + 12'(4 * i), rv);
        apb_wr(12'hFE0, 32'hFFFF_FFFF);
        apb_rd(12'hFE0, rv);
        chk("R10", rv, 32'h31);

        // R9: control write ignored, counting continues
        apb_wr(12'h00C, 32'd0);
        apb_rd(12'h00C, rv);
        chk("R9", rv, 32'd1);

        // R5: upper mask bits dropped
        apb_wr(12'h010, 32'hFFFF_FFFE);
        apb_rd(12'h010, rv);
        chk("R5", rv, 32'd0);

        // R12 + R8: wrap onto a match at zero, interrupt unmasked
        apb_wr(12'h004, 32'd0);
        apb_wr(12'h010, 32'd1);
        apb_wr(12'h01C, 32'd0);
        apb_wr_on_tick(12'h008, 32'hFFFF_FFFF);
        apb_rd(12'h000, rv);
        chk("R3", rv, 32'hFFFF_FFFF);
        while (m_pc != HZ - 1) @(negedge clk);
        @(negedge clk);
        apb_rd(12'h000, rv);
        chk("R12", rv, 32'd0);
        apb_rd(12'h014, rv);
        chk("R8", rv, 32'd1);
        chk("R7", {31'd0, irq_o}, 32'd1);

        // R6: plain clear, then clear against a coinciding match
        apb_wr(12'h01C, 32'h1234_5678);
        apb_rd(12'h014, rv);
        chk("R6", rv, 32'd0);
        apb_wr(12'h004, 32'd100);
        apb_wr(12'h008, 32'd99);
        apb_wr_on_tick(12'h01C, 32'd0);
        apb_rd(12'h014, rv);
        chk("R6", rv, 32'd1);

        // R3: load wins against a tick in the same cycle
        apb_wr_on_tick(12'h008, 32'hA5A5_0000);
        apb_rd(12'h000, rv);
        chk("R3", rv, 32'hA5A5_0000);

        // R11: reserved write leaves state alone, misaligned read is zero
        apb_wr(12'h024, 32'hDEAD_BEEF);
        apb_rd(12'h004, rv);
        chk("R11", rv, 32'd100);
        apb_rd(12'h006, rv);

        // random mix
        for (int n = 0; n < 700; n++) begin
            logic [11:0] a = pool[$urandom % 12];
            int unsigned op = $urandom % 8;
            if (op == 0)      apb_wr(12'h004, m_cnt + ($urandom % 3));
            else if (op < 3)  apb_wr(a, $urandom);
            else if (op < 7)  apb_rd(a, rv);
            else              repeat ($urandom % 5) @(negedge clk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule